// File: doc/BRIEF.md
# Overcurrent Pulse-Skip and Fault Latch Controller

This block sequences the protection response of one switching power channel. It advances by one step for each switching-cycle tick. The overcurrent comparator result is sampled once per switching period, at the moment the current measurement is valid. While that result is high, the block holds back the next high-side pulse. The first trip opens a two-part observation window. In the first part, pulses are skipped but the channel is never shut down. A trip in the second part shuts the channel down. A quiet second part returns the logic to rest at the end of the sixteenth tick.

Two voltage flags act alongside the current logic. An under-voltage flag shuts the channel down on the next clock and does not wait for a tick. An over-voltage flag forces the low-side gate on while it lasts and latches nothing. A shutdown stays in place until both channel enables are low together, or until the synchronous power-on reset. A fault status output tells the power-good logic that the channel is shut down or that an over-voltage is in progress.

Top module: `ocp_guard`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `hs_inhibit`, `ls_force`, `chan_off` and `fault_stat` are all 0.
- R2: `oc_flag` is looked at only on clocks where `cyc_tick` is 1. After such a clock, `hs_inhibit` equals the sampled `oc_flag`, unless the channel is shut down or an over-voltage is active. Between ticks, `hs_inhibit` holds its value.
- R3: The tick that first finds `oc_flag` high is window tick 1. A high `oc_flag` on window ticks 2 to 8 never sets `chan_off`.
- R4: A high `oc_flag` on any of window ticks 9 to 16 sets `chan_off` on the clock after that tick.
- R5: If `oc_flag` is low on all of window ticks 9 to 16, the logic returns to rest after tick 16. A high `oc_flag` on the 17th tick then counts as a new window tick 1 and does not shut down.
- R6: `uv_flag` high on any clock (tick or not) sets `chan_off` on the next clock.
- R7: While `chan_off` is 1, `hs_inhibit` is 1. `ls_force` is 0 unless an over-voltage is active.
- R8: `ov_flag` high on a clock makes `ls_force` and `hs_inhibit` 1 on the next clock, in any state. `ls_force` drops one clock after `ov_flag` drops, and over-voltage never sets `chan_off`.
- R9: `chan_off` clears on the clock after `en_a` and `en_b` are both low on the same clock; this takes precedence over `uv_flag`. One low enable alone has no effect on the shutdown.
- R10: `fault_stat` is 1 exactly when `chan_off` is 1 or `ls_force` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle at the current sample point |
| oc_flag | input | 1 | Overcurrent comparator result, valid when `cyc_tick` is 1 |
| uv_flag | input | 1 | Output below the under-voltage limit |
| ov_flag | input | 1 | Output above the over-voltage limit |
| en_a | input | 1 | Channel enable, first input |
| en_b | input | 1 | Channel enable, second input |
| hs_inhibit | output | 1 | Suppress the next high-side pulse |
| ls_force | output | 1 | Request the low-side gate on |
| chan_off | output | 1 | Channel shut down and latched |
| fault_stat | output | 1 | Fault indication for power-good logic |

## Verification
Two collisions are provoked deliberately. In the first, an over-voltage arrives while the channel is already shut down; the check is that `ls_force` goes high while `chan_off` and `hs_inhibit` stay high. In the second, the enable-pair clear lands on a clock where `uv_flag` is high; the check is that the clear wins for that clock, and that the channel shuts down again once an enable returns with the flag still high. The window boundaries are swept by placing a single repeat trip on each tick from 2 to 17. The expected shutdown comes from the tick number alone, with extra non-tick clocks carrying a high `oc_flag` placed between ticks.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WIN1  = 2'd1,
        ST_WIN2  = 2'd2,
        ST_LATCH = 2'd3
    } ocp_state_e;

    typedef struct packed {
        logic tick;
        logic oc;
        logic uv;
        logic clr;
    } ocp_evt_t;

    function automatic logic both_low(input logic a, input logic b);
        return !a && !b;
    endfunction

endpackage

// File: rtl/ocp_seq.sv
module ocp_seq
    import ocp_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  ocp_evt_t   evt,
    output ocp_state_e state,
    output logic       latched
);
    localparam int CW = $clog2(2 * WIN_CYC);
    localparam logic [CW-1:0] LAST1 = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] LAST2 = CW'(2 * WIN_CYC - 1);

    ocp_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (evt.clr) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else if (evt.uv) begin
            st_n  = ST_LATCH;
            cnt_n = '0;
        end else if (evt.tick) begin
            case (st_q)
                ST_IDLE: begin
                    if (evt.oc) begin
                        st_n  = ST_WIN1;
                        cnt_n = CW'(1);
                    end
                end
                ST_WIN1: begin
                    cnt_n = cnt_q + CW'(1);
                    if (cnt_q == LAST1) st_n = ST_WIN2;
                end
                ST_WIN2: begin
                    if (evt.oc) begin
                        st_n  = ST_LATCH;
                        cnt_n = '0;
                    end else if (cnt_q == LAST2) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + CW'(1);
                    end
                end
                default: st_n = ST_LATCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign state   = st_q;
    assign latched = (st_q == ST_LATCH);

    assert_win1_no_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WIN1 && !evt.uv && !evt.clr) |=> (st_q != ST_LATCH));
    assert_win2_trip_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WIN2 && evt.tick && evt.oc && !evt.clr) |=> (st_q == ST_LATCH));
    assert_idle_cnt_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (cnt_q == '0));
    assert_uv_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.uv && !evt.clr) |=> (st_q == ST_LATCH));
    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LATCH && !evt.clr) |=> (st_q == ST_LATCH));
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        evt.clr |=> (st_q == ST_IDLE));
endmodule

// File: rtl/ocp_skip.sv
module ocp_skip (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic oc,
    input  logic clr,
    output logic skip
);
    logic skip_q;

    always_ff @(posedge clk) begin
        if (rst || clr) skip_q <= 1'b0;
        else if (tick)  skip_q <= oc;
    end

    assign skip = skip_q;

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(skip_q));
endmodule

// File: rtl/ocp_drive.sv
module ocp_drive (
    input  logic clk,
    input  logic rst,
    input  logic ov,
    input  logic latched,
    input  logic skip,
    output logic hs_inhibit,
    output logic ls_force,
    output logic chan_off,
    output logic fault_stat
);
    logic ov_q;

    always_ff @(posedge clk) begin
        if (rst) ov_q <= 1'b0;
        else     ov_q <= ov;
    end

    assign ls_force   = ov_q;
    assign chan_off   = latched;
    assign hs_inhibit = latched | skip | ov_q;
    assign fault_stat = latched | ov_q;

    assert_ov_force_R8: assert property (@(posedge clk) disable iff (rst)
        ov |=> ls_force);
    assert_ov_release_R8: assert property (@(posedge clk) disable iff (rst)
        !ov |=> !ls_force);
    assert_off_inhibits_R7: assert property (@(posedge clk) disable iff (rst)
        chan_off |-> hs_inhibit);
    assert_fault_cover_R10: assert property (@(posedge clk) disable iff (rst)
        (chan_off || ls_force) |-> fault_stat);
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
    import ocp_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic oc_flag,
    input  logic uv_flag,
    input  logic ov_flag,
    input  logic en_a,
    input  logic en_b,
    output logic hs_inhibit,
    output logic ls_force,
    output logic chan_off,
    output logic fault_stat
);
    ocp_evt_t   evt;
    ocp_state_e state;
    logic       latched;
    logic       skip;

    always_comb begin
        evt.tick = cyc_tick;
        evt.oc   = oc_flag;
        evt.uv   = uv_flag;
        evt.clr  = both_low(en_a, en_b);
    end

    ocp_seq #(.WIN_CYC(WIN_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .state   (state),
        .latched (latched)
    );

    ocp_skip u_skip (
        .clk  (clk),
        .rst  (rst),
        .tick (cyc_tick),
        .oc   (oc_flag),
        .clr  (evt.clr),
        .skip (skip)
    );

    ocp_drive u_drive (
        .clk        (clk),
        .rst        (rst),
        .ov         (ov_flag),
        .latched    (latched),
        .skip       (skip),
        .hs_inhibit (hs_inhibit),
        .ls_force   (ls_force),
        .chan_off   (chan_off),
        .fault_stat (fault_stat)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!chan_off && !ls_force));
    assert_state_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH) |-> chan_off);
endmodule

// File: tb/ocp_guard_tb.sv
module ocp_guard_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_tick = 1'b0, oc_flag = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
    logic en_a = 1'b1, en_b = 1'b1;
    logic hs_inhibit, ls_force, chan_off, fault_stat;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ocp_guard u_dut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .oc_flag(oc_flag),
        .uv_flag(uv_flag), .ov_flag(ov_flag), .en_a(en_a), .en_b(en_b),
        .hs_inhibit(hs_inhibit), .ls_force(ls_force),
        .chan_off(chan_off), .fault_stat(fault_stat)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic oc, input logic uv, input logic ov,
                        input logic ea, input logic eb);
        @(negedge clk);
        cyc_tick = t; oc_flag = oc; uv_flag = uv; ov_flag = ov; en_a = ea; en_b = eb;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step(0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R10 checked alongside every status sample
    task automatic chk_fault();
        chk("R10 fault_stat", fault_stat, chan_off | ls_force);
    endtask

    initial begin
        #1_500_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 hs_inhibit", hs_inhibit, 1'b0);
        chk("R1 ls_force", ls_force, 1'b0);
        chk("R1 chan_off", chan_off, 1'b0);
        chk("R1 fault_stat", fault_stat, 1'b0);
        step(0, 0, 0, 0, 1, 1);
        chk("R1 chan_off after release", chan_off, 1'b0);

        // Sweep: trip on tick 1, one repeat on tick k (2..17); extra non-tick clocks carry oc high.
        for (int k = 2; k <= 17; k++) begin
            do_reset();
            for (int i = 1; i <= 20; i++) begin
                logic ocv, lat_exp;
                ocv = (i == 1) || (i == k);
                lat_exp = (k >= 9) && (k <= 16) && (i >= k);
                step(1, ocv, 0, 0, 1, 1);
                // R3 ticks 2..8 never shut down; R4 ticks 9..16 do; R5 tick 17 restarts
                chk((k <= 8) ? "R3 chan_off" : ((k <= 16) ? "R4 chan_off" : "R5 chan_off"),
                    chan_off, lat_exp);
                chk(lat_exp ? "R7 hs_inhibit latched" : "R2 hs_inhibit follows tick",
                    hs_inhibit, lat_exp | ocv);
                chk_fault();
                for (int j = 0; j < 2; j++) begin
                    step(0, 1, 0, 0, 1, 1);
                    chk("R2 hs_inhibit holds between ticks", hs_inhibit, lat_exp | ocv);
                end
            end
        end

        // R4 persistent overcurrent: tick 9 shuts down
        do_reset();
        for (int i = 1; i <= 9; i++) begin
            step(1, 1, 0, 0, 1, 1);
            chk("R4 persistent oc", chan_off, (i == 9));
        end
        chk("R7 ls_force low when off", ls_force, 1'b0);

        // R6 under-voltage on a non-tick clock
        do_reset();
        step(0, 0, 1, 0, 1, 1);
        chk("R6 uv latch", chan_off, 1'b1);
        step(0, 0, 0, 0, 1, 1);
        chk("R6 uv stays latched", chan_off, 1'b1);
        chk("R7 hs_inhibit", hs_inhibit, 1'b1);
        chk("R7 ls_force", ls_force, 1'b0);
        chk_fault();

        // R8 with shutdown: over-voltage while latched
        step(0, 0, 0, 1, 1, 1);
        chk("R8 ls_force while off", ls_force, 1'b1);
        chk("R7 chan_off kept", chan_off, 1'b1);
        chk("R7 hs_inhibit kept", hs_inhibit, 1'b1);
        chk_fault();
        step(0, 0, 0, 0, 1, 1);
        chk("R8 ls_force release", ls_force, 1'b0);

        // R9 one enable low does nothing
        step(0, 0, 0, 0, 0, 1);
        chk("R9 single enable low", chan_off, 1'b1);
        step(0, 0, 0, 0, 1, 0);
        chk("R9 other enable low", chan_off, 1'b1);
        // R9 clear wins over uv in the same clock
        step(0, 0, 1, 0, 0, 0);
        chk("R9 clear over uv", chan_off, 1'b0);
        chk_fault();
        step(0, 0, 1, 0, 1, 0);
        chk("R9 relatch after enable returns", chan_off, 1'b1);
        step(0, 0, 0, 0, 0, 0);
        chk("R9 clear", chan_off, 1'b0);
        step(0, 0, 0, 0, 1, 1);
        chk("R9 stays clear", chan_off, 1'b0);

        // R8 over-voltage alone: non-latching
        step(0, 0, 0, 1, 1, 1);
        chk("R8 ls_force", ls_force, 1'b1);
        chk("R8 hs_inhibit", hs_inhibit, 1'b1);
        chk("R8 no latch", chan_off, 1'b0);
        chk_fault();
        step(1, 0, 0, 1, 1, 1);
        chk("R8 ls_force held", ls_force, 1'b1);
        step(0, 0, 0, 0, 1, 1);
        chk("R8 ls_force drop", ls_force, 1'b0);
        chk("R8 hs_inhibit drop", hs_inhibit, 1'b0);
        chk("R8 still no latch", chan_off, 1'b0);
        chk_fault();

        // R1 reset clears a shutdown
        step(0, 0, 1, 0, 1, 1);
        chk("R6 latch before reset", chan_off, 1'b1);
        do_reset();
        chk("R1 reset clears latch", chan_off, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule